// File: doc/BRIEF.md
# Ten-Point Scoreboard Counter with Leading-Zero Suppression

This block keeps the score of a reaction game and drives a four-position seven-segment scoreboard. Every hit pulse is worth ten points. The units position therefore always reads "0". The tens and hundreds positions are two cascaded decimal counters. The tens counter's wrap from 9 to 0 steps the hundreds counter. A manual clear input returns the score to zero.

Leading zeros are suppressed by a blanking chain that runs from the most significant position downwards. The hundreds digit is dark whenever it is zero and no thousands digit is lit. The tens digit is dark only when the hundreds position is dark and the tens value is zero. A cleared board therefore shows only the units "0". The parameter `SHOW_THOUSAND` picks how a score past 990 is handled:
- With `SHOW_THOUSAND` set to 1 (the default), a two-state controller enters `ST_MAX`. In that state the thousands position shows "1" and the board reads 1000. The next hit returns the board to zero.
- With `SHOW_THOUSAND` set to 0, the count wraps straight from 990 to 0, and the thousands position stays dark.

The controller has two states:
- `ST_COUNT`: the normal counting state. It moves to `ST_MAX` on the hundreds carry, but only when `SHOW_THOUSAND` is 1.
- `ST_MAX`: the board reads 1000. It returns to `ST_COUNT` on a hit or on a clear.

From any state, a clear goes to `ST_COUNT`.

Top module: `score_board`

## Requirements
- R1: A cycle with `clr` high sets both counters to zero and the controller to `ST_COUNT`, from the next clock edge on. The board then shows the units "0" and nothing else.
- R2: In `ST_COUNT`, a cycle with `hit` high and `clr` low adds one to the tens digit at that clock edge, going from 9 to 0. A cycle without `hit` leaves the score unchanged.
- R3: At the same clock edge where the tens digit wraps from 9 to 0, the hundreds digit advances by one.
- R4: `seg_units` is always 7'h3F and `blank_units` is always 0.
- R5: `blank_hund` is 1 exactly when the hundreds digit is 0 and the thousands position is dark.
- R6: `blank_tens` is 1 exactly when `blank_hund` is 1 and the tens digit is 0.
- R7: Every position whose blank flag is 1 drives all segment bits to 0.
- R8: Segment bit 0 is segment a, up to bit 6, which is segment g. All segments are active-high. The patterns for digits 0 through 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R9: With `SHOW_THOUSAND` = 1, a hit at a score of 990 gives the board 1000 for exactly one state. In that state `seg_thou` is 7'h06, and the tens and hundreds positions show an unblanked "0". The next hit returns the board to 0.
- R10: With `SHOW_THOUSAND` = 0, a hit at 990 gives a score of 0 directly, and `blank_thou` stays 1 at all times.
- R11: When `clr` and `hit` are both high in one cycle, the clear wins and the score becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Manual clear, synchronous, active high |
| hit | input | 1 | Score pulse, one cycle per ten points |
| seg_units | output | 7 | Units segments, bit 0 = a |
| seg_tens | output | 7 | Tens segments |
| seg_hund | output | 7 | Hundreds segments |
| seg_thou | output | 7 | Thousands segments |
| blank_units | output | 1 | Units blank flag (always 0) |
| blank_tens | output | 1 | Tens blank flag |
| blank_hund | output | 1 | Hundreds blank flag |
| blank_thou | output | 1 | Thousands blank flag |

## Verification
The two functions that can fall in the same cycle are clear and advance. A hit may arrive in the very cycle the operator clears the board. It may also arrive in the cycle where a tens carry ripples into the hundreds counter, or where the board leaves the 1000 state.

The bench drives long runs of hits, with a gap every seventh cycle, so that carries, the 1000 state and the wrap are all crossed. It also raises `clr` together with `hit` in the middle of a count. A behavioural score model is updated on every edge, with the clear taking priority. Each cycle, both design variants are compared position by position against that model.

// File: rtl/score_pkg.sv
package score_pkg;
    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;

    typedef logic [DIGIT_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0]   seg_t;

    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_MAX   = 1'b1
    } sb_state_e;
endpackage

// File: rtl/sb_bcd_counter.sv
module sb_bcd_counter
    import score_pkg::*;
#(
    parameter int RADIX = 10
) (
    input  logic clk,
    input  logic clr,
    input  logic inc,
    output bcd_t digit,
    output logic carry
);
    localparam bcd_t LAST = bcd_t'(RADIX - 1);

    bcd_t digit_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            digit_q <= '0;
        end else if (inc) begin
            digit_q <= (digit_q == LAST) ? '0 : digit_q + bcd_t'(1);
        end
    end

    assign digit = digit_q;
    assign carry = inc && (digit_q == LAST);

    // R2: no advance means the digit holds
    a_r2_hold: assert property (@(posedge clk) disable iff (clr)
        !inc |=> $stable(digit_q));

    // R2: an advance below the last value steps by one
    a_r2_step: assert property (@(posedge clk) disable iff (clr)
        (inc && digit_q != LAST) |=> (digit_q == $past(digit_q) + bcd_t'(1)));

    // R3: a carry leaves the digit at zero
    a_r3_wrap: assert property (@(posedge clk) disable iff (clr)
        carry |=> (digit_q == '0));

    // R8: the digit stays a legal decimal value
    a_r8_range: assert property (@(posedge clk) disable iff (clr)
        digit_q <= LAST);
endmodule

// File: rtl/sb_seg_encode.sv
module sb_seg_encode
    import score_pkg::*;
(
    input  bcd_t digit,
    input  logic blank,
    output seg_t seg
);
    seg_t pattern;

    always_comb begin
        unique case (digit)
            4'd0:    pattern = 7'h3F;
            4'd1:    pattern = 7'h06;
            4'd2:    pattern = 7'h5B;
            4'd3:    pattern = 7'h4F;
            4'd4:    pattern = 7'h66;
            4'd5:    pattern = 7'h6D;
            4'd6:    pattern = 7'h7D;
            4'd7:    pattern = 7'h07;
            4'd8:    pattern = 7'h7F;
            4'd9:    pattern = 7'h6F;
            default: pattern = '0;
        endcase
    end

    assign seg = blank ? '0 : pattern;

    // R7: a blanked position is dark
    always_comb begin
        a_r7_dark: assert (!blank || seg == '0);
    end
endmodule

// File: rtl/score_board.sv
module score_board
    import score_pkg::*;
#(
    parameter bit SHOW_THOUSAND = 1'b1,
    parameter int NUM_CNT       = 2
) (
    input  logic       clk,
    input  logic       clr,
    input  logic       hit,
    output logic [6:0] seg_units,
    output logic [6:0] seg_tens,
    output logic [6:0] seg_hund,
    output logic [6:0] seg_thou,
    output logic       blank_units,
    output logic       blank_tens,
    output logic       blank_hund,
    output logic       blank_thou
);
    localparam int TOP = NUM_CNT - 1;

    sb_state_e state_q, state_d;

    bcd_t digit [NUM_CNT];
    logic inc   [NUM_CNT];
    logic carry [NUM_CNT];
    logic blk   [NUM_CNT];
    seg_t seg   [NUM_CNT];
    logic thou_on;

    // state register
    always_ff @(posedge clk) begin
        if (clr) state_q <= ST_COUNT;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT: if (SHOW_THOUSAND && carry[TOP]) state_d = ST_MAX;
            ST_MAX:   if (hit)                         state_d = ST_COUNT;
            default:                                   state_d = ST_COUNT;
        endcase
    end

    // outputs of the controller
    always_comb begin
        unique case (state_q)
            ST_MAX:  begin thou_on = 1'b1; inc[0] = 1'b0;  end
            default: begin thou_on = 1'b0; inc[0] = hit;   end
        endcase
    end

    // cascaded counters, with the blanking chain running from the top down
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_stage
        if (i > 0) begin : g_inc
            assign inc[i] = carry[i-1];
        end
        if (i == TOP) begin : g_top_blk
            assign blk[i] = !thou_on && (digit[i] == '0);
        end else begin : g_mid_blk
            assign blk[i] = blk[i+1] && (digit[i] == '0);
        end

        sb_bcd_counter #(.RADIX(10)) u_cnt (
            .clk   (clk),
            .clr   (clr),
            .inc   (inc[i]),
            .digit (digit[i]),
            .carry (carry[i])
        );

        sb_seg_encode u_enc (
            .digit (digit[i]),
            .blank (blk[i]),
            .seg   (seg[i])
        );
    end

    sb_seg_encode u_enc_units (
        .digit (4'd0),
        .blank (1'b0),
        .seg   (seg_units)
    );

    sb_seg_encode u_enc_thou (
        .digit (4'd1),
        .blank (!thou_on),
        .seg   (seg_thou)
    );

    assign seg_tens    = seg[0];
    assign seg_hund    = seg[TOP];
    assign blank_units = 1'b0;
    assign blank_tens  = blk[0];
    assign blank_hund  = blk[TOP];
    assign blank_thou  = !thou_on;

    // R11, R1: a clear wins over a hit and zeroes the score
    a_r11_clear_wins: assert property (@(posedge clk)
        clr |=> (digit[0] == '0 && digit[TOP] == '0 && state_q == ST_COUNT));

    // R3: a tens carry moves the hundreds digit
    a_r3_cascade: assert property (@(posedge clk) disable iff (clr)
        carry[0] |=> !$stable(digit[TOP]));

    // R6: tens is dark only under a dark hundreds
    a_r6_chain: assert property (@(posedge clk) disable iff (clr)
        blank_tens |-> blank_hund);

    // R9: the 1000 state lasts until the next hit
    a_r9_single: assert property (@(posedge clk) disable iff (clr)
        (state_q == ST_MAX && hit) |=> (state_q == ST_COUNT && digit[0] == '0));

    // R10: without the thousands option the 1000 state is never reached
    a_r10_no_max: assert property (@(posedge clk) disable iff (clr)
        !SHOW_THOUSAND |-> (state_q == ST_COUNT));
endmodule

// File: tb/tb_score_board.sv
module tb_score_board;
    logic clk = 1'b0;
    logic clr = 1'b1;
    logic hit = 1'b0;
    always #10 clk = ~clk;

    logic [6:0] su, st, sh, sk, wu, wt, wh, wk;
    logic       bu, bt, bh, bk, xu, xt, xh, xk;

    score_board #(.SHOW_THOUSAND(1'b1)) dut (
        .clk(clk), .clr(clr), .hit(hit),
        .seg_units(su), .seg_tens(st), .seg_hund(sh), .seg_thou(sk),
        .blank_units(bu), .blank_tens(bt), .blank_hund(bh), .blank_thou(bk));

    score_board #(.SHOW_THOUSAND(1'b0)) dut_wrap (
        .clk(clk), .clr(clr), .hit(hit),
        .seg_units(wu), .seg_tens(wt), .seg_hund(wh), .seg_thou(wk),
        .blank_units(xu), .blank_tens(xt), .blank_hund(xh), .blank_thou(xk));

    int total = 0;
    int fails = 0;
    int sc_a = 0;   // score in tens for dut, 100 means the 1000 state
    int sc_b = 0;   // score in tens for dut_wrap
    bit live = 1'b0;

    function automatic logic [6:0] exp_seg(int d, bit blank);
        logic [6:0] p;
        case (d)
            0: p = 7'h3F; 1: p = 7'h06; 2: p = 7'h5B; 3: p = 7'h4F; 4: p = 7'h66;
            5: p = 7'h6D; 6: p = 7'h7D; 7: p = 7'h07; 8: p = 7'h7F; default: p = 7'h6F;
        endcase
        return blank ? 7'h00 : p;
    endfunction

    task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp(int sc, bit show, logic [6:0] u, logic [6:0] t, logic [6:0] h,
                       logic [6:0] k, logic ub, logic tb_, logic hb, logic kb);
        bit thou = (sc == 100);
        int dt = thou ? 0 : sc % 10;
        int dh = thou ? 0 : sc / 10;
        bit eh = !thou && dh == 0;
        bit et = eh && dt == 0;
        chk(u == 7'h3F && ub == 1'b0, "R4 units", {ub, u}, 8'h3F);
        chk(t == exp_seg(dt, et) && tb_ == et, "R2 R6 R7 R8 tens", {tb_, t}, {et, exp_seg(dt, et)});
        chk(h == exp_seg(dh, eh) && hb == eh, "R3 R5 R7 hundreds", {hb, h}, {eh, exp_seg(dh, eh)});
        chk(k == (thou ? 7'h06 : 7'h00) && kb == !thou, show ? "R9 thousands" : "R10 thousands",
            {kb, k}, {!thou, (thou ? 7'h06 : 7'h00)});
    endtask

    // reference model: clear first, then the hit
    function automatic int step(int sc, bit show, bit c, bit h);
        if (c) return 0;
        if (!h) return sc;
        if (sc == 100) return 0;
        if (sc == 99) return show ? 100 : 0;
        return sc + 1;
    endfunction

    always @(posedge clk) begin
        sc_a = step(sc_a, 1'b1, clr, hit);
        sc_b = step(sc_b, 1'b0, clr, hit);
    end

    always @(negedge clk) begin
        if (live) begin
            cmp(sc_a, 1'b1, su, st, sh, sk, bu, bt, bh, bk);
            cmp(sc_b, 1'b0, wu, wt, wh, wk, xu, xt, xh, xk);
        end
    end

    task automatic cycle(bit c, bit h);
        clr = c;
        hit = h;
        @(negedge clk);
    endtask

    initial begin
        #150000;
        total++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        @(negedge clk);
        cycle(1'b1, 1'b0);
        live = 1'b1;
        cycle(1'b0, 1'b0);
        // R1: after the clear only the units zero is lit
        chk(bt && bh && bk && st == 0 && sh == 0, "R1 reset board", {bt, bh, bk}, 8'h07);
        // run through carries, 1000 state and wrap
        for (int i = 0; i < 1200; i++) cycle(1'b0, (i % 7) != 3);
        for (int i = 0; i < 27; i++) cycle(1'b0, 1'b1);
        // R11: clear and hit together
        cycle(1'b1, 1'b1);
        cycle(1'b0, 1'b0);
        chk(bt && bh && st == 0, "R11 clear beats hit", {bt, bh}, 8'h03);
        for (int i = 0; i < 115; i++) cycle(1'b0, 1'b1);
        cycle(1'b1, 1'b0);
        cycle(1'b0, 1'b1);
        // R2: a single hit after the clear shows a lit tens "1"
        cycle(1'b0, 1'b0);
        chk(st == 7'h06 && !bt && bh, "R2 single hit", {bt, st}, 8'h06);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule